// File: doc/BRIEF.md
# Programmable LCD Timing Generator

This block produces the raster timing for a TFT panel. It runs on the pixel clock and takes three packed timing words. From them it builds horizontal sync, vertical sync and a data-enable window, and it reports the current pixel column and line. It also gives a one-cycle strobe when a new frame starts. The block decodes the register encodings itself. Some fields hold their value minus one, some hold it directly, and the active width is counted in units of `H_UNIT` pixels (16 by default). The block does no memory fetch, no pixel formatting and no clock generation.

Each line runs in the order active pixels, front porch, sync pulse, back porch. Each frame runs through the same order, counted in lines. Software can invert each of the three timing outputs separately. A flag that selects the pixel-clock edge passes straight through to the output stage.

Two control inputs govern operation. `ctrlEnable` starts the raster. `ctrlPower` requests panel power, and the block grants it only once the controller has already been running. When the raster is stopped, every timing output rests at its inactive level.

Top module: `lcd_timing_gen`

## Requirements
- R1: A line lasts (P+1)*H_UNIT + (F+1) + (S+1) + (B+1) clocks, in the order active, front porch, sync, back porch. The fields sit in `timWord0`: P in [7:2], S in [15:8], F in [23:16] and B in [31:24]. The logical hsync is high exactly during the S+1 sync clocks.
- R2: A frame lasts (L+1) + VF + (VS+1) + VB lines, in the order active, front porch, sync, back porch. The fields sit in `timWord1`: L in [9:0], VS in [15:10], VF in [23:16] and VB in [31:24]. VF and VB are direct counts, and a value of 0 gives no lines in that phase. The logical vsync is high for whole lines during the VS+1 sync lines.
- R3: The logical data enable is high only for an active pixel (column below (P+1)*H_UNIT) on an active line (line below L+1). `pixelX` and `pixelY` give the column and line, counted from 0, of the clock whose timing the outputs show.
- R4: `frameStart` is high for exactly one clock per frame, on the clock that shows column 0 of line 0, and only while enabled.
- R5: Each timing output equals its logical level XOR an invert bit in `timWord2`: bit 12 for hsync, bit 11 for vsync and bit 14 for data enable.
- R6: `pixClkFallOut` always equals `timWord2` bit 13, with no delay.
- R7: When `ctrlEnable` is low at a clock edge, the next clock shows every logical level low, `frameStart` low and position 0,0. When enable returns, the first enabled edge brings out column 0 of line 0.
- R8: `panelPowerOut` is high after an edge only if, at that edge, `ctrlPower` and `ctrlEnable` were both high and `ctrlEnable` was also high at the edge before. It drops on the first edge at which either input is low.
- R9: While `rst_n` is low, the logical levels, `frameStart`, the position outputs and `panelPowerOut` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| timWord0 | input | 32 | Horizontal timing fields |
| timWord1 | input | 32 | Vertical timing fields |
| timWord2 | input | 32 | Polarity and clock-edge flags |
| ctrlEnable | input | 1 | Runs the raster counters |
| ctrlPower | input | 1 | Requests panel power |
| hsyncOut | output | 1 | Horizontal sync after inversion |
| vsyncOut | output | 1 | Vertical sync after inversion |
| dataEnOut | output | 1 | Data enable after inversion |
| pixelX | output | H_CNT_W (11) | Current column |
| pixelY | output | V_CNT_W (11) | Current line |
| frameStart | output | 1 | One-clock strobe at the frame origin |
| pixClkFallOut | output | 1 | Pixel-clock edge select, passed through |
| panelPowerOut | output | 1 | Sequenced panel power |

## Verification
The bench builds the block with the default `H_UNIT` of 16, so the counter widths come out at 11 bits. It programs porch and sync fields of zero up to small values, which gives lines of 22 to 120 clocks and frames of 5 to 12 lines. Many complete frames therefore fit into a short run. These settings reach the zero-length vertical porches, the case where the minimum field value adds one and the case where it adds nothing, and the frame wrap several times in each configuration. A behavioural model builds the phase sequence of each line and each frame as queues, and it compares every output on every clock. The run includes all invert bits set, a stop in the middle of a frame and power requested in the same clock as enable.

// File: rtl/lcd_timing_pkg.sv
package lcd_timing_pkg;
  // Field positions inside the timing words
  localparam int ACT_UNITS_LSB = 2;
  localparam int ACT_UNITS_W   = 6;
  localparam int HSYNC_LSB     = 8;
  localparam int HFRONT_LSB    = 16;
  localparam int HBACK_LSB     = 24;
  localparam int HFIELD_W      = 8;
  localparam int LINES_LSB     = 0;
  localparam int LINES_W       = 10;
  localparam int VSYNC_LSB     = 10;
  localparam int VSYNC_W       = 6;
  localparam int VFRONT_LSB    = 16;
  localparam int VBACK_LSB     = 24;
  localparam int VFIELD_W      = 8;
  localparam int INV_VS_BIT    = 11;
  localparam int INV_HS_BIT    = 12;
  localparam int INV_PCLK_BIT  = 13;
  localparam int INV_DE_BIT    = 14;

  typedef struct packed {
    logic lineWrap;
    logic frameWrap;
    logic inHSync;
    logic inVSync;
    logic inActive;
    logic firstPixel;
  } strobes_t;
endpackage

// File: rtl/lcd_timing_ctrl.sv
module lcd_timing_ctrl
  import lcd_timing_pkg::*;
#(
  parameter int H_UNIT = 16,
  parameter int HCW    = 11,
  parameter int VCW    = 11
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           enable,
  input  logic           powerReq,
  input  logic [31:0]    tw0,
  input  logic [31:0]    tw1,
  input  logic [HCW-1:0] hCount,
  input  logic [VCW-1:0] vCount,
  output strobes_t       strb,
  output logic           panelPower
);
  logic [ACT_UNITS_W-1:0] actUnits;
  logic [HFIELD_W-1:0]    hSyncM1, hFrontM1, hBackM1;
  logic [LINES_W-1:0]     linesM1;
  logic [VSYNC_W-1:0]     vSyncM1;
  logic [VFIELD_W-1:0]    vFront, vBack;
  logic [1:0]             unusedLowBits;

  assign actUnits      = tw0[ACT_UNITS_LSB +: ACT_UNITS_W];
  assign hSyncM1       = tw0[HSYNC_LSB +: HFIELD_W];
  assign hFrontM1      = tw0[HFRONT_LSB +: HFIELD_W];
  assign hBackM1       = tw0[HBACK_LSB +: HFIELD_W];
  assign unusedLowBits = tw0[1:0];
  assign linesM1       = tw1[LINES_LSB +: LINES_W];
  assign vSyncM1       = tw1[VSYNC_LSB +: VSYNC_W];
  assign vFront        = tw1[VFRONT_LSB +: VFIELD_W];
  assign vBack         = tw1[VBACK_LSB +: VFIELD_W];

  // Horizontal phase boundaries (minus-one fields restored)
  logic [HCW-1:0] hActEnd, hSyncBeg, hSyncEnd, hTotal;
  assign hActEnd  = (HCW'(actUnits) + HCW'(1)) * HCW'(H_UNIT);
  assign hSyncBeg = hActEnd + HCW'(hFrontM1) + HCW'(1);
  assign hSyncEnd = hSyncBeg + HCW'(hSyncM1) + HCW'(1);
  assign hTotal   = hSyncEnd + HCW'(hBackM1) + HCW'(1);

  // Vertical phase boundaries (porches are direct counts)
  logic [VCW-1:0] vActEnd, vSyncBeg, vSyncEnd, vTotal;
  assign vActEnd  = VCW'(linesM1) + VCW'(1);
  assign vSyncBeg = vActEnd + VCW'(vFront);
  assign vSyncEnd = vSyncBeg + VCW'(vSyncM1) + VCW'(1);
  assign vTotal   = vSyncEnd + VCW'(vBack);

  always_comb begin
    strb.inActive   = (hCount < hActEnd) && (vCount < vActEnd);
    strb.inHSync    = (hCount >= hSyncBeg) && (hCount < hSyncEnd);
    strb.inVSync    = (vCount >= vSyncBeg) && (vCount < vSyncEnd);
    strb.lineWrap   = hCount >= (hTotal - HCW'(1));
    strb.frameWrap  = strb.lineWrap && (vCount >= (vTotal - VCW'(1)));
    strb.firstPixel = (hCount == '0) && (vCount == '0);
  end

  // Power follows enable by at least one clock and drops first
  logic runQ;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      runQ       <= 1'b0;
      panelPower <= 1'b0;
    end else begin
      runQ       <= enable;
      panelPower <= enable && powerReq && runQ;
    end
  end
endmodule

// File: rtl/lcd_timing_dp.sv
module lcd_timing_dp
  import lcd_timing_pkg::*;
#(
  parameter int HCW = 11,
  parameter int VCW = 11
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           enable,
  input  strobes_t       strb,
  output logic [HCW-1:0] hCount,
  output logic [VCW-1:0] vCount,
  output logic           hsLvl,
  output logic           vsLvl,
  output logic           deLvl,
  output logic           fsLvl,
  output logic [HCW-1:0] xOut,
  output logic [VCW-1:0] yOut
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hCount <= '0;
      vCount <= '0;
      hsLvl  <= 1'b0;
      vsLvl  <= 1'b0;
      deLvl  <= 1'b0;
      fsLvl  <= 1'b0;
      xOut   <= '0;
      yOut   <= '0;
    end else if (!enable) begin
      hCount <= '0;
      vCount <= '0;
      hsLvl  <= 1'b0;
      vsLvl  <= 1'b0;
      deLvl  <= 1'b0;
      fsLvl  <= 1'b0;
      xOut   <= '0;
      yOut   <= '0;
    end else begin
      hsLvl <= strb.inHSync;
      vsLvl <= strb.inVSync;
      deLvl <= strb.inActive;
      fsLvl <= strb.firstPixel;
      xOut  <= hCount;
      yOut  <= vCount;
      if (strb.lineWrap) begin
        hCount <= '0;
        if (strb.frameWrap) vCount <= '0;
        else                vCount <= vCount + VCW'(1);
      end else begin
        hCount <= hCount + HCW'(1);
      end
    end
  end
endmodule

// File: rtl/lcd_timing_gen.sv
module lcd_timing_gen
  import lcd_timing_pkg::*;
#(
  parameter int H_UNIT = 16,
  localparam int H_CNT_W = $clog2((1 << ACT_UNITS_W) * H_UNIT + 3 * (1 << HFIELD_W) + 1),
  localparam int V_CNT_W = $clog2((1 << LINES_W) + (1 << VSYNC_W) + 2 * (1 << VFIELD_W) + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [31:0]        timWord0,
  input  logic [31:0]        timWord1,
  input  logic [31:0]        timWord2,
  input  logic               ctrlEnable,
  input  logic               ctrlPower,
  output logic               hsyncOut,
  output logic               vsyncOut,
  output logic               dataEnOut,
  output logic [H_CNT_W-1:0] pixelX,
  output logic [V_CNT_W-1:0] pixelY,
  output logic               frameStart,
  output logic               pixClkFallOut,
  output logic               panelPowerOut
);
  strobes_t           strb;
  logic [H_CNT_W-1:0] hCount;
  logic [V_CNT_W-1:0] vCount;
  logic               hsLvl, vsLvl, deLvl;
  logic               unusedTw2;

  lcd_timing_ctrl #(.H_UNIT(H_UNIT), .HCW(H_CNT_W), .VCW(V_CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .enable(ctrlEnable), .powerReq(ctrlPower),
    .tw0(timWord0), .tw1(timWord1), .hCount(hCount), .vCount(vCount),
    .strb(strb), .panelPower(panelPowerOut)
  );

  lcd_timing_dp #(.HCW(H_CNT_W), .VCW(V_CNT_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .enable(ctrlEnable), .strb(strb),
    .hCount(hCount), .vCount(vCount), .hsLvl(hsLvl), .vsLvl(vsLvl),
    .deLvl(deLvl), .fsLvl(frameStart), .xOut(pixelX), .yOut(pixelY)
  );

  // Polarity stage: one XOR per timing output
  logic [2:0] lvlVec, invVec, outVec;
  assign lvlVec = {deLvl, vsLvl, hsLvl};
  assign invVec = {timWord2[INV_DE_BIT], timWord2[INV_VS_BIT], timWord2[INV_HS_BIT]};
  for (genvar i = 0; i < 3; i++) begin : g_pol
    assign outVec[i] = lvlVec[i] ^ invVec[i];
  end
  assign hsyncOut      = outVec[0];
  assign vsyncOut      = outVec[1];
  assign dataEnOut     = outVec[2];
  assign pixClkFallOut = timWord2[INV_PCLK_BIT];
  assign unusedTw2     = ^{timWord2[31:15], timWord2[10:0]};
endmodule

// File: rtl/lcd_timing_checks.sv
module lcd_timing_checks #(
  parameter int HCW = 11,
  parameter int VCW = 11
) (
  input logic           clk,
  input logic           rst_n,
  input logic           ctrlEnable,
  input logic           invHs,
  input logic           invVs,
  input logic           invDe,
  input logic           hsyncOut,
  input logic           vsyncOut,
  input logic           dataEnOut,
  input logic           frameStart,
  input logic [HCW-1:0] pixelX,
  input logic [VCW-1:0] pixelY,
  input logic           panelPowerOut
);
  logic hsL, vsL, deL;
  assign hsL = hsyncOut ^ invHs;
  assign vsL = vsyncOut ^ invVs;
  assign deL = dataEnOut ^ invDe;

  assert_sync_outside_active_R1: assert property (@(posedge clk) disable iff (!rst_n)
    deL |-> !hsL);

  assert_column_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (deL && pixelX != '0) |-> (pixelX == HCW'($past(pixelX) + 1'b1)));

  assert_frame_origin_R4: assert property (@(posedge clk) disable iff (!rst_n)
    frameStart |-> (pixelX == '0 && pixelY == '0 && deL));

  assert_idle_inactive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(ctrlEnable) |-> (!hsL && !vsL && !deL && !frameStart && pixelX == '0 && pixelY == '0));

  assert_power_after_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    panelPowerOut |-> $past(ctrlEnable));
endmodule

bind lcd_timing_gen lcd_timing_checks #(.HCW(H_CNT_W), .VCW(V_CNT_W)) u_checks (
  .clk(clk), .rst_n(rst_n), .ctrlEnable(ctrlEnable),
  .invHs(timWord2[12]), .invVs(timWord2[11]), .invDe(timWord2[14]),
  .hsyncOut(hsyncOut), .vsyncOut(vsyncOut), .dataEnOut(dataEnOut),
  .frameStart(frameStart), .pixelX(pixelX), .pixelY(pixelY),
  .panelPowerOut(panelPowerOut)
);

// File: tb/test_lcd_timing_gen.sv
`timescale 1ns/1ps
module test_lcd_timing_gen;
  localparam int HW = 11;
  localparam int VW = 11;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [31:0]   timWord0 = '0, timWord1 = '0, timWord2 = '0;
  logic          ctrlEnable = 1'b0, ctrlPower = 1'b0;
  logic          hsyncOut, vsyncOut, dataEnOut, frameStart, pixClkFallOut, panelPowerOut;
  logic [HW-1:0] pixelX;
  logic [VW-1:0] pixelY;

  lcd_timing_gen i_lcd_timing_gen (
    .clk(clk), .rst_n(rst_n), .timWord0(timWord0), .timWord1(timWord1),
    .timWord2(timWord2), .ctrlEnable(ctrlEnable), .ctrlPower(ctrlPower),
    .hsyncOut(hsyncOut), .vsyncOut(vsyncOut), .dataEnOut(dataEnOut),
    .pixelX(pixelX), .pixelY(pixelY), .frameStart(frameStart),
    .pixClkFallOut(pixClkFallOut), .panelPowerOut(panelPowerOut)
  );

  always #10 clk = ~clk;  // 50 MHz

  int nChecks = 0;
  int nFail = 0;
  int cycles = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Reference model: phase queues per line and per frame (0 act, 1 front, 2 sync, 3 back)
  int hq[$];
  int vq[$];
  int mh = 0, mv = 0;
  bit mRun = 0;
  bit eHs = 0, eVs = 0, eDe = 0, eFs = 0, ePow = 0;
  int eX = 0, eY = 0;

  task automatic configure(input int p, input int s, input int f, input int b,
                           input int l, input int vs, input int vf, input int vb,
                           input logic [31:0] flags);
    hq.delete();
    vq.delete();
    repeat ((p + 1) * 16) hq.push_back(0);
    repeat (f + 1) hq.push_back(1);
    repeat (s + 1) hq.push_back(2);
    repeat (b + 1) hq.push_back(3);
    repeat (l + 1) vq.push_back(0);
    repeat (vf) vq.push_back(1);
    repeat (vs + 1) vq.push_back(2);
    repeat (vb) vq.push_back(3);
    timWord0 = (32'(p) << 2) | (32'(s) << 8) | (32'(f) << 16) | (32'(b) << 24);
    timWord1 = 32'(l) | (32'(vs) << 10) | (32'(vf) << 16) | (32'(vb) << 24);
    timWord2 = flags;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mh = 0; mv = 0; mRun = 0;
      eHs = 0; eVs = 0; eDe = 0; eFs = 0; ePow = 0; eX = 0; eY = 0;
    end else begin
      ePow = ctrlEnable && ctrlPower && mRun;
      mRun = ctrlEnable;
      if (ctrlEnable) begin
        eHs = (hq[mh] == 2);
        eVs = (vq[mv] == 2);
        eDe = (hq[mh] == 0) && (vq[mv] == 0);
        eFs = (mh == 0) && (mv == 0);
        eX = mh; eY = mv;
        mh++;
        if (mh == hq.size()) begin
          mh = 0;
          mv++;
          if (mv == vq.size()) mv = 0;
        end
      end else begin
        mh = 0; mv = 0;
        eHs = 0; eVs = 0; eDe = 0; eFs = 0; eX = 0; eY = 0;
      end
    end
  end

  // Compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      if (!rst_n) begin
        chk("R9", "reset frameStart", frameStart, 0);
        chk("R9", "reset pixelX", pixelX, 0);
        chk("R9", "reset pixelY", pixelY, 0);
        chk("R9", "reset power", panelPowerOut, 0);
        chk("R9", "reset data enable level", dataEnOut ^ timWord2[14], 0);
      end else begin
        chk("R1", "hsync", hsyncOut, eHs ^ timWord2[12]);
        chk("R2", "vsync", vsyncOut, eVs ^ timWord2[11]);
        chk("R3", "data enable", dataEnOut, eDe ^ timWord2[14]);
        chk("R3", "pixelX", pixelX, eX);
        chk("R3", "pixelY", pixelY, eY);
        chk("R4", "frameStart", frameStart, eFs);
        chk("R6", "pixel clock edge flag", pixClkFallOut, timWord2[13]);
        chk("R8", "panel power", panelPowerOut, ePow);
        if (!mRun) chk("R7", "idle position", pixelX + pixelY, 0);
        if (timWord2[12]) chk("R5", "inverted hsync", hsyncOut, !eHs);
      end
    end
  end

  task automatic run(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  initial begin
    run(4);
    rst_n = 1'b1;
    run(3);
    // Config A: 22-clock lines, 5-line frames, one-line vertical front porch
    configure(0, 0, 1, 2, 2, 0, 1, 0, 32'h0);
    run(2);
    ctrlEnable = 1'b1;
    run(3);
    ctrlPower = 1'b1;
    run(340);
    ctrlPower = 1'b0;
    run(3);
    ctrlEnable = 1'b0;
    run(10);
    // Config B: all inversions, no vertical front porch, power with enable
    configure(1, 2, 0, 0, 1, 1, 0, 2, 32'h0000_7800);
    run(2);
    ctrlEnable = 1'b1;
    ctrlPower = 1'b1;
    run(500);
    ctrlEnable = 1'b0;  // R7: stop mid-frame, power must drop
    run(6);
    ctrlEnable = 1'b1;
    run(300);
    ctrlEnable = 1'b0;
    ctrlPower = 1'b0;
    run(6);
    // Config C: wider line, all four vertical phases present
    configure(3, 7, 15, 31, 4, 2, 3, 1, 32'h0000_2000);
    run(2);
    ctrlEnable = 1'b1;
    run(2);
    ctrlPower = 1'b1;
    run(3000);
    ctrlEnable = 1'b0;
    run(5);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      nChecks++;
      nFail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end
endmodule